// File: doc/BRIEF.md
# Vectored Interrupt Controller Core

This block collects 64 level-sensitive interrupt sources and drives two processor request lines: a normal request (`irq`) and a fast request (`fiq`). Each source is latched into a pending vector when its level changes. It is gated by a per-source enable bit and steered to one of the two outputs by a per-source type bit. Normal requests are further filtered by a 4-bit per-source priority, compared against a software-programmed threshold. Both request lines are computed combinationally from the stored state.

Software reaches the block through a 32-bit register bus addressed by word index, with one write strobe and one read strobe. Sources can be enabled or disabled one at a time by writing a source number, or a whole 32-bit half at a time. A force register lets software overwrite the pending vector directly. Finding the highest-priority request is left to an external resolver. This block exports the masked request vectors and the packed priorities to it, and returns the resolver's answers when the two vector words are read.

Top module: `vic_core`

## Requirements
- R1: After reset, pending, enable, type, control and every priority read as zero, the threshold reads 31, and `irq` and `fiq` are low.
- R2: When a source input changes level, its pending bit takes the new level at the next clock edge. Word 18 reads pending bits 63:32 and word 19 reads bits 31:0.
- R3: A write to word 2 sets the enable bit numbered by `bus_wdata[5:0]`, and a write to word 3 clears that bit; both words read zero. Words 4 and 5 read and write enable bits 63:32 and 31:0.
- R4: Words 6 and 7 read and write type bits 63:32 and 31:0, where a type bit of 1 marks a fast source. `fiq` is high exactly when some source is pending, enabled and fast.
- R5: Words 8 to 15 hold the priorities. Word 15-w holds sources 8w to 8w+7, and source n uses bits 4*(n%8)+3 down to 4*(n%8). `prio_flat` carries source n's priority at bits 4n+3 down to 4n.
- R6: Word 1 holds a 5-bit threshold. While it is 31, `irq` is high exactly when some source is pending, enabled and normal (type 0).
- R7: For any other threshold, `irq` is high only when some pending, enabled, normal source has a priority strictly above the threshold.
- R8: A write to word 20 replaces pending bits 63:32, and a write to word 21 replaces bits 31:0. These writes take precedence over a source change in the same cycle. Both words read zero.
- R9: Words 22/23 read pending&enable&~type (high/low), and words 24/25 read pending&enable&type. The same full vectors appear on `norm_req` and `fast_req`.
- R10: Word 16 reads `norm_vec_in` and word 17 reads `fast_vec_in`. Writes to words 16 to 19, 22 to 25, 64 to 191 and to any undefined word change nothing. Word 64 reads 4, and undefined words read 0.
- R11: Word 0 keeps only bits 24 and 22 to 18 of a write. Bit 25 is an abort flag that is cleared by writing 1 while bit 24 is set; nothing in this block sets it, so it reads 0.
- R12: `bus_rdata` is registered. It takes the addressed word's value, as it stood before the edge, at a clock edge with `bus_rd` high, and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_lvl | input | 64 | Source levels |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_idx | input | 10 | Word index (byte offset divided by 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Normal interrupt request |
| fiq | output | 1 | Fast interrupt request |
| norm_req | output | 64 | Pending, enabled, normal sources (to resolver) |
| fast_req | output | 64 | Pending, enabled, fast sources (to resolver) |
| prio_flat | output | 256 | Packed priorities (to resolver) |
| norm_vec_in | input | 32 | Resolver result returned on word 16 |
| fast_vec_in | input | 32 | Resolver result returned on word 17 |

## Verification
The bench builds the block with its default parameters: 64 sources, 32-bit words, 4-bit priorities and a 5-bit threshold. With these values the highest source (63), the top priority word (sources 56 to 63), and both threshold extremes (30 against priority 15, and the bypass value 31) can all be reached. Random traffic mixes source toggles with writes across the whole index range, including the ignored window. A reference model predicts every read and both request lines after each cycle.

// File: rtl/vic_core.sv
module vic_core #(
  parameter int NSRC = 64,
  parameter int DW   = 32,
  parameter int IW   = 10,
  parameter int PW   = 4,
  parameter int MW   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NSRC-1:0]    src_lvl,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [IW-1:0]      bus_idx,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  output logic               irq,
  output logic               fiq,
  output logic [NSRC-1:0]    norm_req,
  output logic [NSRC-1:0]    fast_req,
  output logic [NSRC*PW-1:0] prio_flat,
  input  logic [DW-1:0]      norm_vec_in,
  input  logic [DW-1:0]      fast_vec_in
);
  localparam int PPW = DW / PW;
  localparam int NPW = NSRC / PPW;
  localparam int SNW = $clog2(NSRC);
  localparam logic [MW-1:0] THR_OFF  = '1;
  localparam logic [DW-1:0] CTRL_KEEP = 32'h017C_0000;

  logic [NSRC-1:0]          pend_q, en_q, typ_q, srcq_q, pend_d;
  logic [NPW-1:0][DW-1:0]   prio_q;
  logic [MW-1:0]            thr_q;
  logic [DW-1:0]            ctrl_q, rd_d;
  logic                     prio_hit;

  wire wr_at = bus_wr;

  assign norm_req  = pend_q & en_q & ~typ_q;
  assign fast_req  = pend_q & en_q & typ_q;
  assign prio_flat = prio_q;
  assign fiq       = |fast_req;

  always_comb begin
    prio_hit = 1'b0;
    for (int i = 0; i < NSRC; i++)
      if (norm_req[i] && ({{(MW-PW){1'b0}}, prio_flat[i*PW +: PW]} > thr_q))
        prio_hit = 1'b1;
  end

  assign irq = (thr_q == THR_OFF) ? |norm_req : prio_hit;

  always_comb begin
    pend_d = (pend_q & ~(src_lvl ^ srcq_q)) | (src_lvl & (src_lvl ^ srcq_q));
    if (wr_at && bus_idx == IW'(20)) pend_d[NSRC-1:DW] = bus_wdata;
    if (wr_at && bus_idx == IW'(21)) pend_d[DW-1:0]    = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      srcq_q <= '0;
      en_q   <= '0;
      typ_q  <= '0;
      prio_q <= '0;
      thr_q  <= THR_OFF;
      ctrl_q <= '0;
    end else begin
      srcq_q <= src_lvl;
      pend_q <= pend_d;
      if (wr_at) begin
        case (bus_idx)
          IW'(0): ctrl_q <= bus_wdata & CTRL_KEEP;
          IW'(1): thr_q  <= bus_wdata[MW-1:0];
          IW'(2): en_q[bus_wdata[SNW-1:0]] <= 1'b1;
          IW'(3): en_q[bus_wdata[SNW-1:0]] <= 1'b0;
          IW'(4): en_q[NSRC-1:DW]  <= bus_wdata;
          IW'(5): en_q[DW-1:0]     <= bus_wdata;
          IW'(6): typ_q[NSRC-1:DW] <= bus_wdata;
          IW'(7): typ_q[DW-1:0]    <= bus_wdata;
          IW'(8), IW'(9), IW'(10), IW'(11),
          IW'(12), IW'(13), IW'(14), IW'(15):
            prio_q[~bus_idx[2:0]] <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (bus_idx)
      IW'(0):  rd_d = ctrl_q;
      IW'(1):  rd_d = DW'(thr_q);
      IW'(4):  rd_d = en_q[NSRC-1:DW];
      IW'(5):  rd_d = en_q[DW-1:0];
      IW'(6):  rd_d = typ_q[NSRC-1:DW];
      IW'(7):  rd_d = typ_q[DW-1:0];
      IW'(8), IW'(9), IW'(10), IW'(11),
      IW'(12), IW'(13), IW'(14), IW'(15):
               rd_d = prio_q[~bus_idx[2:0]];
      IW'(16): rd_d = norm_vec_in;
      IW'(17): rd_d = fast_vec_in;
      IW'(18): rd_d = pend_q[NSRC-1:DW];
      IW'(19): rd_d = pend_q[DW-1:0];
      IW'(22): rd_d = norm_req[NSRC-1:DW];
      IW'(23): rd_d = norm_req[DW-1:0];
      IW'(24): rd_d = fast_req[NSRC-1:DW];
      IW'(25): rd_d = fast_req[DW-1:0];
      IW'(64): rd_d = DW'(4);
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_d;
  end

  assert_en_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_idx == IW'(2)) |=> en_q[$past(bus_wdata[SNW-1:0])]);

  assert_en_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_idx == IW'(3)) |=> !en_q[$past(bus_wdata[SNW-1:0])]);

  assert_force_lo_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_idx == IW'(21)) |=> pend_q[DW-1:0] == $past(bus_wdata));

  assert_force_hi_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_idx == IW'(20)) |=> pend_q[NSRC-1:DW] == $past(bus_wdata));

  assert_ro_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_idx >= IW'(16)) && (bus_idx != IW'(20)) && (bus_idx != IW'(21)))
      |=> ($stable(en_q) && $stable(typ_q) && $stable(thr_q) && $stable(prio_q)));

  assert_irq_needs_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|(pend_q & en_q & ~typ_q)));

  assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  assert_ctrl_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[25] == 1'b0);
endmodule

// File: tb/test_vic_core.sv
`timescale 1ns/1ps
module test_vic_core;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [63:0]  src_lvl = '0;
  logic         bus_wr = 1'b0, bus_rd = 1'b0;
  logic [9:0]   bus_idx = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         irq, fiq;
  logic [63:0]  norm_req, fast_req;
  logic [255:0] prio_flat;
  logic [31:0]  norm_vec_in = 32'h0013_0007, fast_vec_in = 32'h0000_0021;

  vic_core i_vic_core (.*);

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;
  logic [63:0] m_pend = '0, m_en = '0, m_typ = '0, m_srcq = '0;
  logic [255:0] m_prio = '0;
  logic [4:0] m_thr = 5'd31;
  logic [31:0] m_ctrl = '0, m_rd = '0;

  task automatic check(string tag, logic [255:0] act, logic [255:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rdval(int idx);
    case (idx)
      0: return m_ctrl;
      1: return {27'd0, m_thr};
      4: return m_en[63:32];  5: return m_en[31:0];
      6: return m_typ[63:32]; 7: return m_typ[31:0];
      8, 9, 10, 11, 12, 13, 14, 15: return m_prio[(15-idx)*32 +: 32];
      16: return norm_vec_in; 17: return fast_vec_in;
      18: return m_pend[63:32]; 19: return m_pend[31:0];
      22: return (m_pend & m_en & ~m_typ) >> 32;
      23: return 32'(m_pend & m_en & ~m_typ);
      24: return (m_pend & m_en & m_typ) >> 32;
      25: return 32'(m_pend & m_en & m_typ);
      64: return 32'd4;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic exp_irq();
    logic [63:0] nr = m_pend & m_en & ~m_typ;
    if (m_thr == 5'd31) return |nr;
    for (int i = 0; i < 64; i++)
      if (nr[i] && ({1'b0, m_prio[4*i +: 4]} > m_thr)) return 1'b1;
    return 1'b0;
  endfunction

  task automatic model_edge();
    logic [63:0] chg = src_lvl ^ m_srcq;
    logic [63:0] np = (m_pend & ~chg) | (src_lvl & chg);
    if (bus_rd) m_rd = rdval(int'(bus_idx));
    m_srcq = src_lvl;
    if (bus_wr) begin
      case (int'(bus_idx))
        0: m_ctrl = bus_wdata & 32'h017C_0000;
        1: m_thr = bus_wdata[4:0];
        2: m_en[bus_wdata[5:0]] = 1'b1;
        3: m_en[bus_wdata[5:0]] = 1'b0;
        4: m_en[63:32] = bus_wdata;  5: m_en[31:0] = bus_wdata;
        6: m_typ[63:32] = bus_wdata; 7: m_typ[31:0] = bus_wdata;
        8, 9, 10, 11, 12, 13, 14, 15: m_prio[(15-int'(bus_idx))*32 +: 32] = bus_wdata;
        20: np[63:32] = bus_wdata;
        21: np[31:0] = bus_wdata;
        default: ;
      endcase
    end
    m_pend = np;
  endtask

  task automatic cyc();
    logic was_rd = bus_rd;
    int ridx = int'(bus_idx);
    model_edge();
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
    bus_rd = 1'b0;
    if (was_rd) begin
      if (ridx == 2 || ridx == 3) check("R3 read zero", bus_rdata, m_rd);
      else if (ridx == 20 || ridx == 21) check("R8 read zero", bus_rdata, m_rd);
      else if (ridx >= 8 && ridx <= 15) check("R5 prio word", bus_rdata, m_rd);
      else if (ridx >= 22 && ridx <= 25) check("R9 pending view", bus_rdata, m_rd);
      else if (ridx == 18 || ridx == 19) check("R2 raw source", bus_rdata, m_rd);
      else if (ridx == 0) check("R11 control", bus_rdata, m_rd);
      else check("R10/R12 read", bus_rdata, m_rd);
    end
    check(m_thr == 5'd31 ? "R6 irq" : "R7 irq", irq, exp_irq());
    check("R4 fiq", fiq, |(m_pend & m_en & m_typ));
  endtask

  task automatic wr(int idx, logic [31:0] d);
    bus_wr = 1'b1; bus_idx = 10'(idx); bus_wdata = d;
    cyc();
  endtask

  task automatic rd(int idx);
    bus_rd = 1'b1; bus_idx = 10'(idx);
    cyc();
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", irq, 1'b0);
    check("R1 fiq", fiq, 1'b0);
    check("R1 prio", prio_flat, 256'd0);
    for (int k = 0; k < 26; k++) begin
      rd(k);
      if (k == 1) check("R1 threshold", bus_rdata, 32'd31);
      else if (k != 16 && k != 17) check("R1 zero", bus_rdata, 32'd0);
    end
    rd(64); check("R10 const", bus_rdata, 32'd4);
    rd(300); check("R10 undef", bus_rdata, 32'd0);
    // R3 enable by number, extremes
    wr(2, 32'hFFFF_FFC0 | 32'd63); wr(2, 32'd0);
    rd(4); check("R3 en63", bus_rdata, 32'h8000_0000);
    rd(5); check("R3 en0", bus_rdata, 32'h0000_0001);
    wr(3, 32'd63); rd(4); check("R3 dis63", bus_rdata, 32'd0);
    // R5 packing
    wr(15, 32'h7654_3210); wr(8, 32'hFEDC_BA98);
    check("R5 src0", prio_flat[3:0], 4'h0);
    check("R5 src7", prio_flat[31:28], 4'h7);
    check("R5 src56", prio_flat[227:224], 4'h8);
    check("R5 src63", prio_flat[255:252], 4'hF);
    // R2 source level -> pending; R6/R7 threshold corners on source 5 (prio 5)
    src_lvl[5] = 1'b1; cyc();
    check("R2 pend5", i_vic_core.norm_req[5] | 1'b0, 1'b0);
    rd(19); check("R2 pend5 raw", bus_rdata, 32'h20);
    check("R6 no enable", irq, 1'b0);
    wr(2, 32'd5); check("R6 bypass irq", irq, 1'b1);
    wr(1, 32'd4); check("R7 above", irq, 1'b1);
    wr(1, 32'd5); check("R7 equal", irq, 1'b0);
    src_lvl[63] = 1'b1; wr(2, 32'd63);
    wr(1, 32'd30); check("R7 prio15 vs 30", irq, 1'b0);
    wr(1, 32'd14); check("R7 prio15 vs 14", irq, 1'b1);
    wr(7, 32'h20); check("R4 fiq on", fiq, 1'b1);
    // R8 force precedence over source change
    src_lvl[0] = 1'b1; wr(21, 32'h0);
    rd(19); check("R8 force wins", bus_rdata, 32'd0);
    // R11 control
    wr(0, 32'hFFFF_FFFF); rd(0); check("R11 keep", bus_rdata, 32'h017C_0000);
    // R10 ignored window
    wr(100, 32'hFFFF_FFFF); wr(191, 32'hFFFF_FFFF); wr(16, 32'hFFFF_FFFF);
    rd(5); rd(7); rd(1);
    // random traffic
    for (int it = 0; it < 3000; it++) begin
      int op = $urandom % 10;
      if (($urandom % 4) == 0) src_lvl[$urandom % 64] ^= 1'b1;
      if (op < 5) begin
        int sel = $urandom % 8;
        int idx = (sel < 6) ? int'($urandom % 26) : (sel == 6) ? 64 + int'($urandom % 128) : int'($urandom % 1024);
        logic [31:0] d = $urandom;
        if (idx == 1) d = (($urandom % 3) == 0) ? 32'd31 : ($urandom % 16);
        if (idx == 6 || idx == 7) d = d & $urandom & $urandom;
        wr(idx, d);
      end else if (op < 9) begin
        rd(($urandom % 5 == 0) ? int'($urandom % 256) : int'($urandom % 26));
      end else begin
        norm_vec_in = $urandom; fast_vec_in = $urandom;
        cyc();
      end
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule